// File: doc/BRIEF.md
# Gate Schedule List Compiler

This block turns a software-supplied gate schedule into the compiled list that a time-aware transmit scheduler reads. A start pulse latches the number of windows, the cycle time, the cycle-time extension and an acknowledge timeout. The windows then arrive one per cycle on a valid/ready stream, each carrying an 8-bit gate mask (one bit per transmit queue) and a 32-bit interval in nanoseconds.

Every configuration is validated before anything is written. A configuration that passes is written word by word into the shadow copy of the schedule memory. That copy holds three things: the window masks, the window end times and a table of per-queue gate close times. The end time of a window is the running sum of the intervals up to that window, except that the last window is stretched to the full cycle time. The block then raises a list-swap request and holds it until the scheduler acknowledges. If no acknowledge comes within the programmed number of clock cycles, the block reports a timeout instead. The done and error flags, together with a reason code, remain set until the next accepted start.

Top module: `gsl_compiler`

## Requirements
- R1: After reset, busy, done, err, ent_ready, mem_we and list_swap_req are all low and err_code is 0.
- R2: A start with cfg_count of 0 or above 16 ends at once with err high, err_code 1 and busy low. No entry is accepted and no memory word is written.
- R3: A start with a legal count but a nonzero cfg_extension ends at once with err high and err_code 2. The count test has priority over this one. No memory word is written.
- R4: If any of the streamed entries has a zero interval, all cfg_count entries are still consumed. The block then ends with err high, err_code 3 and no memory word written.
- R5: Address w (0..15) receives the mask of window w, zero-extended to 32 bits, when w < count, and 0 otherwise.
- R6: Address 16+w receives the sum of the intervals of windows 0..w for the windows before the last valid one. The last valid window (count-1) receives the cycle time, and windows at or above count receive 0.
- R7: Address 32+8*w+q receives the end time of window w when w < count and mask bit q of that window is set, and 0 otherwise.
- R8: Writes start only after the last entry has been accepted. They cover addresses 0 to 159 in ascending order, one per cycle, with no gap.
- R9: After the last write, list_swap_req stays high until swap_ack. The cycle after swap_ack, done is high, err is low and busy is low.
- R10: If swap_ack never arrives, list_swap_req stays high for exactly cfg_timeout+1 cycles. It then drops, and err goes high with err_code 4.
- R11: done, err and err_code hold their values until the next start accepted while idle. A start while busy is ignored.
- R12: ent_ready is high only while entries are being collected. Exactly cfg_count entries are taken, one per cycle on which ent_valid and ent_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compilation (sampled only while idle) |
| cfg_count | input | 5 | Number of schedule windows |
| cfg_cycle | input | 32 | Cycle time in ns |
| cfg_extension | input | 32 | Cycle-time extension; must be zero |
| cfg_timeout | input | 16 | Acknowledge timeout in clock cycles |
| ent_valid | input | 1 | Entry stream valid |
| ent_mask | input | 8 | Gate mask of the entry, bit q opens queue q |
| ent_interval | input | 32 | Window interval in ns |
| ent_ready | output | 1 | Entry stream ready |
| mem_we | output | 1 | Shadow memory write strobe |
| mem_addr | output | 8 | Shadow memory word address |
| mem_wdata | output | 32 | Shadow memory write data |
| list_swap_req | output | 1 | Request to swap active and shadow lists |
| swap_ack | input | 1 | Scheduler acknowledge of the swap |
| busy | output | 1 | Compilation in progress |
| done | output | 1 | Last compilation succeeded |
| err | output | 1 | Last compilation failed |
| err_code | output | 3 | 0 none, 1 bad count, 2 extension, 3 zero interval, 4 timeout |

## Verification
The assertions assume that the configuration inputs are stable on the cycle start is sampled. They also assume that swap_ack is only raised while the swap request is high. The bench drives all inputs half a cycle away from the active edge, holds the configuration steady across each start pulse and pulses the acknowledge only after it has seen the request. Entry streams present exactly cfg_count entries, so the collector never sees surplus data that it would have to ignore.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

    localparam int unsigned GSL_WIN_DEF  = 16;
    localparam int unsigned GSL_QUEUE_DEF = 8;
    localparam int unsigned GSL_TIME_W   = 32;
    localparam int unsigned GSL_TMO_W    = 16;

    typedef enum logic [2:0] {
        GSL_OK       = 3'd0,
        GSL_BAD_CNT  = 3'd1,
        GSL_EXTEND   = 3'd2,
        GSL_ZERO_IVL = 3'd3,
        GSL_TIMEOUT  = 3'd4
    } gsl_err_e;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_COLLECT,
        GS_EMIT,
        GS_WAIT
    } gsl_state_e;

    typedef enum logic [1:0] {
        RG_MASK,
        RG_END,
        RG_CLOSE
    } gsl_region_e;

    // Outcome of the header check done on the start cycle
    typedef struct packed {
        logic     reject;
        gsl_err_e reason;
    } gsl_verdict_t;

    function automatic gsl_verdict_t gsl_check_header(
        input int unsigned count,
        input int unsigned max_win,
        input logic        ext_nonzero
    );
        gsl_verdict_t v;
        v.reject = 1'b0;
        v.reason = GSL_OK;
        if (count == 0 || count > max_win) begin
            v.reject = 1'b1;
            v.reason = GSL_BAD_CNT;
        end else if (ext_nonzero) begin
            v.reject = 1'b1;
            v.reason = GSL_EXTEND;
        end
        return v;
    endfunction

endpackage

// File: rtl/gsl_entry_store.sv
module gsl_entry_store #(
    parameter int unsigned N_WIN = 16,
    parameter int unsigned N_Q   = 8,
    parameter int unsigned TW    = 32,
    localparam int unsigned IW   = $clog2(N_WIN),
    localparam int unsigned CW   = $clog2(N_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  logic [N_Q-1:0] in_mask,
    input  logic [TW-1:0] in_ivl,
    input  logic [IW-1:0] rd_win,
    output logic [N_Q-1:0] rd_mask,
    output logic [TW-1:0] rd_sum,
    output logic [CW-1:0] taken,
    output logic          saw_zero
);

    logic [TW-1:0]  run_q;
    logic [TW-1:0]  run_next;
    logic [N_Q-1:0] mask_mem [N_WIN];
    logic [TW-1:0]  sum_mem  [N_WIN];

    assign run_next = run_q + in_ivl;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            taken    <= '0;
            run_q    <= '0;
            saw_zero <= 1'b0;
        end else if (take) begin
            taken <= taken + 1'b1;
            run_q <= run_next;
            if (in_ivl == '0) begin
                saw_zero <= 1'b1;
            end
        end
    end

    // One storage slot per window; each loads when the take index matches
    for (genvar gw = 0; gw < N_WIN; gw++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take && taken == CW'(gw)) begin
                mask_mem[gw] <= in_mask;
                sum_mem[gw]  <= run_next;
            end
        end
    end

    assign rd_mask = mask_mem[rd_win];
    assign rd_sum  = sum_mem[rd_win];

endmodule

// File: rtl/gsl_word_gen.sv
module gsl_word_gen
    import gsl_pkg::*;
#(
    parameter int unsigned N_WIN = 16,
    parameter int unsigned N_Q   = 8,
    parameter int unsigned TW    = 32,
    localparam int unsigned IW   = $clog2(N_WIN),
    localparam int unsigned CW   = $clog2(N_WIN + 1),
    localparam int unsigned QW   = $clog2(N_Q),
    localparam int unsigned N_WORDS = 2 * N_WIN + N_WIN * N_Q,
    localparam int unsigned AW   = $clog2(N_WORDS)
) (
    input  logic [AW-1:0]  idx,
    input  logic [CW-1:0]  count,
    input  logic [TW-1:0]  cycle,
    input  logic [N_Q-1:0] rd_mask,
    input  logic [TW-1:0]  rd_sum,
    output logic [IW-1:0]  rd_win,
    output logic [TW-1:0]  wdata
);

    localparam logic [AW-1:0] END_BASE   = AW'(N_WIN);
    localparam logic [AW-1:0] CLOSE_BASE = AW'(2 * N_WIN);
    localparam logic [AW-1:0] NQ_A       = AW'(N_Q);

    gsl_region_e     region;
    logic [AW-1:0]   win_full;
    logic [AW-1:0]   off;
    logic [QW-1:0]   queue;
    logic            win_valid;
    logic            win_last;
    logic [TW-1:0]   end_val;
    logic [TW-1:0]   close_vec [N_Q];

    always_comb begin
        off = idx - CLOSE_BASE;
        if (idx < END_BASE) begin
            region   = RG_MASK;
            win_full = idx;
        end else if (idx < CLOSE_BASE) begin
            region   = RG_END;
            win_full = idx - END_BASE;
        end else begin
            region   = RG_CLOSE;
            win_full = off / NQ_A;
        end
        queue = QW'(off % NQ_A);
    end

    assign rd_win    = win_full[IW-1:0];
    assign win_valid = win_full < AW'(count);
    assign win_last  = win_full == (AW'(count) - 1'b1);
    assign end_val   = !win_valid ? '0 : (win_last ? cycle : rd_sum);

    // Per-queue close time candidates for the addressed window
    for (genvar gq = 0; gq < N_Q; gq++) begin : g_close
        assign close_vec[gq] = (win_valid && rd_mask[gq]) ? end_val : '0;
    end

    always_comb begin
        unique case (region)
            RG_MASK:  wdata = win_valid ? {{(TW - N_Q){1'b0}}, rd_mask} : '0;
            RG_END:   wdata = end_val;
            default:  wdata = close_vec[queue];
        endcase
    end

endmodule

// File: rtl/gsl_ack_wait.sv
module gsl_ack_wait #(
    parameter int unsigned TOW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    input  logic [TOW-1:0] limit,
    output logic           expired
);

    logic [TOW-1:0] waited;

    assign expired = active && (waited == limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            waited <= '0;
        end else if (!expired) begin
            waited <= waited + 1'b1;
        end
    end

endmodule

// File: rtl/gsl_compiler.sv
module gsl_compiler
    import gsl_pkg::*;
#(
    parameter int unsigned N_WIN = GSL_WIN_DEF,
    parameter int unsigned N_Q   = GSL_QUEUE_DEF,
    parameter int unsigned TW    = GSL_TIME_W,
    parameter int unsigned TOW   = GSL_TMO_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [$clog2(N_WIN+1)-1:0]    cfg_count,
    input  logic [TW-1:0]                 cfg_cycle,
    input  logic [TW-1:0]                 cfg_extension,
    input  logic [TOW-1:0]                cfg_timeout,
    input  logic                          ent_valid,
    input  logic [N_Q-1:0]                ent_mask,
    input  logic [TW-1:0]                 ent_interval,
    output logic                          ent_ready,
    output logic                          mem_we,
    output logic [$clog2(2*N_WIN+N_WIN*N_Q)-1:0] mem_addr,
    output logic [TW-1:0]                 mem_wdata,
    output logic                          list_swap_req,
    input  logic                          swap_ack,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [2:0]                    err_code
);

    localparam int unsigned IW      = $clog2(N_WIN);
    localparam int unsigned CW      = $clog2(N_WIN + 1);
    localparam int unsigned N_WORDS = 2 * N_WIN + N_WIN * N_Q;
    localparam int unsigned AW      = $clog2(N_WORDS);
    localparam logic [AW-1:0] LAST_WORD = AW'(N_WORDS - 1);

    gsl_state_e     state;
    gsl_err_e       code_q;
    gsl_verdict_t   verdict;
    logic [CW-1:0]  count_q;
    logic [TW-1:0]  cycle_q;
    logic [TOW-1:0] tmo_q;
    logic [AW-1:0]  widx;
    logic           done_q;
    logic           err_q;

    logic           accept;
    logic           take;
    logic           last_take;
    logic [CW-1:0]  taken;
    logic           saw_zero;
    logic [IW-1:0]  rd_win;
    logic [N_Q-1:0] rd_mask;
    logic [TW-1:0]  rd_sum;
    logic           expired;

    assign accept    = (state == GS_IDLE) && start;
    assign ent_ready = (state == GS_COLLECT);
    assign take      = ent_valid && ent_ready;
    assign last_take = take && (taken == count_q - 1'b1);

    assign verdict = gsl_check_header(int'(cfg_count), N_WIN, |cfg_extension);

    gsl_entry_store #(
        .N_WIN (N_WIN),
        .N_Q   (N_Q),
        .TW    (TW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .take     (take),
        .in_mask  (ent_mask),
        .in_ivl   (ent_interval),
        .rd_win   (rd_win),
        .rd_mask  (rd_mask),
        .rd_sum   (rd_sum),
        .taken    (taken),
        .saw_zero (saw_zero)
    );

    gsl_word_gen #(
        .N_WIN (N_WIN),
        .N_Q   (N_Q),
        .TW    (TW)
    ) u_words (
        .idx     (widx),
        .count   (count_q),
        .cycle   (cycle_q),
        .rd_mask (rd_mask),
        .rd_sum  (rd_sum),
        .rd_win  (rd_win),
        .wdata   (mem_wdata)
    );

    gsl_ack_wait #(
        .TOW (TOW)
    ) u_wait (
        .clk     (clk),
        .rst     (rst),
        .active  (state == GS_WAIT),
        .limit   (tmo_q),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= GS_IDLE;
            code_q  <= GSL_OK;
            count_q <= '0;
            cycle_q <= '0;
            tmo_q   <= '0;
            widx    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                GS_IDLE: begin
                    if (start) begin
                        done_q  <= 1'b0;
                        count_q <= cfg_count;
                        cycle_q <= cfg_cycle;
                        tmo_q   <= cfg_timeout;
                        err_q   <= verdict.reject;
                        code_q  <= verdict.reason;
                        if (!verdict.reject) begin
                            state <= GS_COLLECT;
                        end
                    end
                end
                GS_COLLECT: begin
                    if (last_take) begin
                        if (saw_zero || ent_interval == '0) begin
                            err_q  <= 1'b1;
                            code_q <= GSL_ZERO_IVL;
                            state  <= GS_IDLE;
                        end else begin
                            widx  <= '0;
                            state <= GS_EMIT;
                        end
                    end
                end
                GS_EMIT: begin
                    widx <= widx + 1'b1;
                    if (widx == LAST_WORD) begin
                        state <= GS_WAIT;
                    end
                end
                default: begin
                    if (swap_ack) begin
                        done_q <= 1'b1;
                        state  <= GS_IDLE;
                    end else if (expired) begin
                        err_q  <= 1'b1;
                        code_q <= GSL_TIMEOUT;
                        state  <= GS_IDLE;
                    end
                end
            endcase
        end
    end

    assign mem_we        = (state == GS_EMIT);
    assign mem_addr      = widx;
    assign list_swap_req = (state == GS_WAIT);
    assign busy          = (state != GS_IDLE);
    assign done          = done_q;
    assign err           = err_q;
    assign err_code      = code_q;

endmodule

// File: rtl/gsl_checker.sv
module gsl_checker #(
    parameter int unsigned N_WIN = 16,
    parameter int unsigned N_Q   = 8,
    parameter int unsigned TW    = 32,
    parameter int unsigned TOW   = 16,
    localparam int unsigned CW   = $clog2(N_WIN + 1),
    localparam int unsigned N_WORDS = 2 * N_WIN + N_WIN * N_Q,
    localparam int unsigned AW   = $clog2(N_WORDS)
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [CW-1:0]  cfg_count,
    input logic [TW-1:0]  cfg_extension,
    input logic           ent_ready,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           list_swap_req,
    input logic           swap_ack,
    input logic           busy,
    input logic           done,
    input logic           err,
    input logic [2:0]     err_code
);

    p_bad_count_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (cfg_count == 0 || cfg_count > CW'(N_WIN)))
        |=> (err && !busy && err_code == 3'd1));

    p_extension_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_count != 0 && cfg_count <= CW'(N_WIN) && cfg_extension != 0)
        |=> (err && !busy && err_code == 3'd2));

    p_addr_range_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr < AW'(N_WORDS)));

    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    p_first_addr_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> (mem_addr == '0));

    p_ack_done_r9: assert property (@(posedge clk) disable iff (rst)
        (list_swap_req && swap_ack) |=> (done && !err && !busy));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (list_swap_req && !swap_ack) |=> (list_swap_req || (err && err_code == 3'd4)));

    p_flags_r11: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_phase_r12: assert property (@(posedge clk) disable iff (rst)
        ent_ready |-> (busy && !mem_we && !list_swap_req));

    p_we_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && !err && !done));

endmodule

bind gsl_compiler gsl_checker #(
    .N_WIN (N_WIN),
    .N_Q   (N_Q),
    .TW    (TW),
    .TOW   (TOW)
) u_gsl_checker (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .cfg_count     (cfg_count),
    .cfg_extension (cfg_extension),
    .ent_ready     (ent_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .list_swap_req (list_swap_req),
    .swap_ack      (swap_ack),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .err_code      (err_code)
);

// File: tb/test_gsl_compiler.sv
`timescale 1ns/1ps
module test_gsl_compiler;

    localparam int NW = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_count = '0;
    logic [31:0] cfg_cycle = '0;
    logic [31:0] cfg_extension = '0;
    logic [15:0] cfg_timeout = '0;
    logic        ent_valid = 1'b0;
    logic [7:0]  ent_mask = '0;
    logic [31:0] ent_interval = '0;
    logic        ent_ready;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        list_swap_req;
    logic        swap_ack = 1'b0;
    logic        busy, done, err;
    logic [2:0]  err_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int wr_cnt = 0;
    int next_addr = 0;
    bit order_bad = 1'b0;
    logic [31:0] shadow [NW];

    int          e_n;
    logic [31:0] e_cyc;
    logic [7:0]  e_mask [16];
    logic [31:0] e_ivl  [16];

    always #4 clk = ~clk;

    gsl_compiler i_gsl_compiler (
        .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count),
        .cfg_cycle(cfg_cycle), .cfg_extension(cfg_extension),
        .cfg_timeout(cfg_timeout), .ent_valid(ent_valid), .ent_mask(ent_mask),
        .ent_interval(ent_interval), .ent_ready(ent_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .list_swap_req(list_swap_req), .swap_ack(swap_ack), .busy(busy),
        .done(done), .err(err), .err_code(err_code)
    );

    // Shadow memory model and write-order monitor
    always @(posedge clk) begin
        if (!rst && mem_we) begin
            shadow[mem_addr] <= mem_wdata;
            if (int'(mem_addr) != next_addr) order_bad = 1'b1;
            next_addr = (int'(mem_addr) == NW - 1) ? 0 : int'(mem_addr) + 1;
            wr_cnt++;
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_end(int w);
        logic [31:0] s = '0;
        if (w >= e_n) return '0;
        if (w == e_n - 1) return e_cyc;
        for (int i = 0; i <= w; i++) s = s + e_ivl[i];
        return s;
    endfunction

    function automatic logic [31:0] exp_word(int idx);
        int w, q;
        if (idx < 16) return (idx < e_n) ? {24'b0, e_mask[idx]} : 32'b0;
        if (idx < 32) return exp_end(idx - 16);
        w = (idx - 32) / 8;
        q = (idx - 32) % 8;
        return (w < e_n && e_mask[w][q]) ? exp_end(w) : 32'b0;
    endfunction

    task automatic fill(int n, int seed, int zpos);
        logic [31:0] tot = '0;
        e_n = n;
        for (int i = 0; i < 16; i++) begin
            e_mask[i] = 8'(i * 37 + seed * 11 + 1);
            e_ivl[i]  = (i == zpos) ? 32'd0 : 32'(100 + i * 13 + seed);
            if (i < n) tot = tot + e_ivl[i];
        end
        e_cyc = tot + 32'd500;
    endtask

    task automatic do_start(int cnt, logic [31:0] ext, int tmo);
        @(negedge clk);
        cfg_count = 5'(cnt);
        cfg_cycle = e_cyc;
        cfg_extension = ext;
        cfg_timeout = 16'(tmo);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(int n);
        for (int i = 0; i < n; i++) begin
            bit r;
            ent_valid = 1'b1;
            ent_mask = e_mask[i];
            ent_interval = e_ivl[i];
            do begin
                r = ent_ready;
                @(negedge clk);
            end while (!r);
        end
        ent_valid = 1'b0;
    endtask

    task automatic wait_req();
        int guard = 0;
        while (!list_swap_req && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic compare_regions();
        int bad [3] = '{0, 0, 0};
        int first [3] = '{0, 0, 0};
        for (int a = 0; a < NW; a++) begin
            int rg = (a < 16) ? 0 : (a < 32) ? 1 : 2;
            if (shadow[a] !== exp_word(a)) begin
                if (bad[rg] == 0) first[rg] = a;
                bad[rg]++;
            end
        end
        chk(bad[0] == 0, "R5", "mask word", shadow[first[0]], exp_word(first[0]));
        chk(bad[1] == 0, "R6", "end word", shadow[first[1]], exp_word(first[1]));
        chk(bad[2] == 0, "R7", "close word", shadow[first[2]], exp_word(first[2]));
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err && !ent_ready && !mem_we && !list_swap_req,
            "R1", "idle outputs", {busy, done, err, ent_ready, mem_we, list_swap_req}, 0);
        chk(err_code == 3'd0, "R1", "err_code", err_code, 0);
    endtask

    task automatic t_bad_count(int cnt);
        int w0 = wr_cnt;
        fill(4, 1, -1);
        do_start(cnt, 0, 50);
        chk(err && !busy && err_code == 3'd1, "R2", "count reject code", err_code, 1);
        chk(!ent_ready, "R2", "no entry accepted", ent_ready, 0);
        repeat (3) @(negedge clk);
        chk(wr_cnt == w0, "R2", "no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_extension();
        int w0 = wr_cnt;
        fill(4, 2, -1);
        do_start(4, 32'd5, 50);
        chk(err && !busy && err_code == 3'd2, "R3", "extension reject", err_code, 2);
        do_start(0, 32'd5, 50);
        chk(err_code == 3'd1, "R3", "count test first", err_code, 1);
        chk(wr_cnt == w0, "R3", "no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_zero(int n, int zpos);
        int w0 = wr_cnt;
        fill(n, 3, zpos);
        do_start(n, 0, 50);
        send(n);
        chk(err && !busy && err_code == 3'd3, "R4", "zero interval code", err_code, 3);
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0, "R4", "no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_program(int n, int seed, int ack_dly);
        int w0 = wr_cnt;
        int hi = 0;
        fill(n, seed, -1);
        do_start(n, 0, 1000);
        send(n);
        chk(wr_cnt == w0, "R8", "no write before last entry", wr_cnt - w0, 0);
        chk(!ent_ready, "R12", "ready drops after count entries", ent_ready, 0);
        wait_req();
        chk(wr_cnt - w0 == NW, "R8", "write count", wr_cnt - w0, NW);
        chk(!order_bad, "R8", "ascending addresses", order_bad, 0);
        repeat (ack_dly) begin
            if (list_swap_req) hi++;
            @(negedge clk);
        end
        chk(list_swap_req && hi == ack_dly, "R9", "request held", hi, ack_dly);
        swap_ack = 1'b1;
        @(negedge clk);
        swap_ack = 1'b0;
        chk(done && !err && !busy && err_code == 3'd0, "R9", "done after ack",
            {done, err, busy}, 3'b100);
        chk(!list_swap_req, "R9", "request drops", list_swap_req, 0);
        compare_regions();
    endtask

    task automatic t_timeout(int tmo);
        int hi = 0;
        fill(2, 7, -1);
        do_start(2, 0, tmo);
        send(2);
        wait_req();
        while (list_swap_req && hi < 500) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == tmo + 1, "R10", "request length", hi, tmo + 1);
        chk(err && !done && err_code == 3'd4, "R10", "timeout code", err_code, 4);
    endtask

    task automatic t_busy_start();
        int w0 = wr_cnt;
        fill(2, 9, -1);
        do_start(2, 0, 1000);
        send(2);
        repeat (10) @(negedge clk);
        cfg_count = 5'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !err, "R11", "start while busy ignored", err, 0);
        wait_req();
        swap_ack = 1'b1;
        @(negedge clk);
        swap_ack = 1'b0;
        chk(done && err_code == 3'd0 && wr_cnt - w0 == NW, "R11", "run completes",
            wr_cnt - w0, NW);
        repeat (6) @(negedge clk);
        chk(done && !err, "R11", "done persists", done, 1);
        do_start(20, 0, 10);
        chk(!done && err && err_code == 3'd1, "R11", "new start clears done",
            {done, err}, 2'b01);
        repeat (6) @(negedge clk);
        chk(err && err_code == 3'd1, "R11", "err persists", err_code, 1);
    endtask

    initial begin
        for (int a = 0; a < NW; a++) shadow[a] = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bad_count(0);
        t_bad_count(17);
        t_extension();
        t_program(16, 4, 3);
        t_zero(5, 2);
        t_zero(3, 2);
        t_program(3, 5, 0);
        t_program(1, 6, 7);
        t_timeout(20);
        t_timeout(0);
        t_busy_start();
        report();
        $finish;
    end

endmodule